// File: doc/BRIEF.md
# Oscillator Reference Divider and Status Select

This block turns a free-running single-ended oscillator into a slow reference pulse train, so that a downstream phase-locked loop can synthesise frequencies when no line sync is present. Each pulse is high for a single oscillator period. It is then low for a programmable number of periods, set by a 7-bit modulus, so the train repeats every modulus + 2 oscillator periods. A modulus of zero is reserved; the block treats it as one.

A select input decides which signal feeds the phase detector. It is either this divided train, or the conditioned line sync after an optional inversion that picks its active edge. A shared status output shows either the loop's lock flag or the reference that the detector is using, under a 2-bit code. The whole block runs on the oscillator clock. A modulus change never cuts short a phase that is already in progress.

Top module: `osc_ref_mux`

## Requirements
- R1: `ref_out` is high for exactly one oscillator clock cycle per period.
- R2: After each high cycle, `ref_out` stays low for `modulus` + 1 cycles, so the period is `modulus` + 2 cycles. This holds for every modulus from 1 to 127.
- R3: A `modulus` of 0 behaves as 1: the output is low for 2 cycles and the period is 3.
- R4: The modulus is captured only on the clock edge that starts a high cycle. A change made during a low phase leaves the length of that low phase unchanged and applies from the next period.
- R5: With `in_sel` = 0, `pd_ref` equals `sync_in` XOR `sync_pol`. With `in_sel` = 1, `pd_ref` equals `ref_out`, and `sync_in` and `sync_pol` have no effect on it.
- R6: `stat_sel` = 2'b00 drives `lock_flag` onto `stat_out`.
- R7: `stat_sel` = 2'b11 drives the detector reference `pd_ref` onto `stat_out`. That is the divided train when `in_sel` = 1 and the polarity-adjusted sync otherwise.
- R8: The reserved codes `stat_sel` = 2'b01 and 2'b10 drive `stat_out` low.
- R9: While `rst_n` is low, `ref_out` is low. The first high cycle begins at the first rising clock edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modulus | input | 7 | Low-phase modulus (0 treated as 1) |
| in_sel | input | 1 | Detector reference select: 0 sync, 1 divided oscillator |
| sync_pol | input | 1 | Inverts the conditioned sync when 1 |
| sync_in | input | 1 | Conditioned line sync |
| lock_flag | input | 1 | Loop lock indication |
| stat_sel | input | 2 | Status output code |
| ref_out | output | 1 | Divided oscillator pulse train |
| pd_ref | output | 1 | Reference delivered to the phase detector |
| stat_out | output | 1 | Shared status output |

## Verification
The hardest case to reach is a modulus change that lands in the middle of a low phase. The change must neither shorten nor stretch that phase, and it must take effect in the following period. The bench first aligns itself to a high cycle by watching `ref_out` between clock edges. It then counts low cycles and rewrites the modulus on the third one. It measures that low phase and the next one against the old and new values. The full sweep of all 128 modulus values uses the same alignment. Each new value is therefore measured only on a period that started after the value was applied.

// File: rtl/osc_ref_pkg.sv
package osc_ref_pkg;

    // Codes of the shared status output; the order matters to the decoder.
    typedef enum logic [1:0] {
        STAT_LOCK  = 2'b00,
        STAT_RSVA  = 2'b01,
        STAT_RSVB  = 2'b10,
        STAT_REF   = 2'b11
    } stat_sel_e;

    // Width of the modulus field.
    localparam int unsigned MOD_W_DEF = 7;

endpackage

// File: rtl/osc_ref_divider.sv
module osc_ref_divider #(
    parameter int unsigned MOD_W = osc_ref_pkg::MOD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] modulus,
    output logic             ref_pulse
);

    localparam logic [MOD_W-1:0] MOD_MIN = MOD_W'(1);

    typedef struct packed {
        logic             hi;   // current cycle is the high cycle
        logic [MOD_W-1:0] cnt;  // low cycles still to run after this one
        logic [MOD_W-1:0] mod;  // modulus captured at the last high cycle
    } div_st_t;

    div_st_t st_d, st_q;
    logic [MOD_W-1:0] mod_eff;

    always_comb begin
        mod_eff = (modulus == '0) ? MOD_MIN : modulus;
        st_d    = st_q;
        if (st_q.hi) begin
            // leave the high cycle; the low phase lasts mod + 1 cycles
            st_d.hi  = 1'b0;
            st_d.cnt = st_q.mod;
        end else if (st_q.cnt == '0) begin
            // last low cycle: start the next high cycle, capture the modulus
            st_d.hi  = 1'b1;
            st_d.mod = mod_eff;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi  <= 1'b0;
            st_q.cnt <= '0;
            st_q.mod <= MOD_MIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_pulse = st_q.hi;

endmodule

// File: rtl/osc_ref_select.sv
module osc_ref_select
    import osc_ref_pkg::*;
(
    input  logic       in_sel,
    input  logic       sync_pol,
    input  logic       sync_in,
    input  logic       div_ref,
    input  logic       lock_flag,
    input  logic [1:0] stat_sel,
    output logic       pd_ref,
    output logic       stat_out
);

    logic sync_adj;
    stat_sel_e code;

    always_comb begin
        sync_adj = sync_in ^ sync_pol;
        pd_ref   = in_sel ? div_ref : sync_adj;
        code     = stat_sel_e'(stat_sel);
        unique case (code)
            STAT_LOCK: stat_out = lock_flag;
            STAT_REF:  stat_out = pd_ref;
            default:   stat_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/osc_ref_mux.sv
module osc_ref_mux #(
    parameter int unsigned MOD_W = osc_ref_pkg::MOD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] modulus,
    input  logic             in_sel,
    input  logic             sync_pol,
    input  logic             sync_in,
    input  logic             lock_flag,
    input  logic [1:0]       stat_sel,
    output logic             ref_out,
    output logic             pd_ref,
    output logic             stat_out
);

    logic div_ref;

    osc_ref_divider #(.MOD_W(MOD_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .modulus   (modulus),
        .ref_pulse (div_ref)
    );

    osc_ref_select i_sel (
        .in_sel    (in_sel),
        .sync_pol  (sync_pol),
        .sync_in   (sync_in),
        .div_ref   (div_ref),
        .lock_flag (lock_flag),
        .stat_sel  (stat_sel),
        .pd_ref    (pd_ref),
        .stat_out  (stat_out)
    );

    assign ref_out = div_ref;

endmodule

// File: rtl/osc_ref_mux_chk.sv
module osc_ref_mux_chk #(
    parameter int unsigned MOD_W = osc_ref_pkg::MOD_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MOD_W-1:0] modulus,
    input logic             in_sel,
    input logic             sync_pol,
    input logic             sync_in,
    input logic             lock_flag,
    input logic [1:0]       stat_sel,
    input logic             ref_out,
    input logic             pd_ref,
    input logic             stat_out
);

    localparam int unsigned RUN_W   = MOD_W + 2;
    localparam int unsigned LOW_MAX = 1 << MOD_W;

    logic [RUN_W-1:0] run_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            seen_q <= 1'b0;
        end else if (ref_out) begin
            run_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    // R1: a high cycle is always followed by a low cycle
    a_r1_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        ref_out |=> !ref_out);

    // R3: the low phase is never shorter than two cycles
    a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_out) |=> !ref_out);

    // R2: each completed low phase lies within the legal range
    a_r2_low_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_out && seen_q) |-> (run_q >= RUN_W'(2) && run_q <= RUN_W'(LOW_MAX)));

    // R5: detector reference follows the selected source
    a_r5_pd_div: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel |-> (pd_ref == ref_out));
    a_r5_pd_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sel |-> (pd_ref == (sync_in ^ sync_pol)));

    // R6: lock code shows the lock flag
    a_r6_stat_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel == 2'b00) |-> (stat_out == lock_flag));

    // R7: reference code shows the detector reference
    a_r7_stat_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel == 2'b11) |-> (stat_out == pd_ref));

    // R8: reserved codes hold the status output low
    a_r8_stat_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sel == 2'b01 || stat_sel == 2'b10) |-> !stat_out);

endmodule

bind osc_ref_mux osc_ref_mux_chk #(.MOD_W(MOD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .modulus   (modulus),
    .in_sel    (in_sel),
    .sync_pol  (sync_pol),
    .sync_in   (sync_in),
    .lock_flag (lock_flag),
    .stat_sel  (stat_sel),
    .ref_out   (ref_out),
    .pd_ref    (pd_ref),
    .stat_out  (stat_out)
);

// File: tb/test_osc_ref_mux.sv
`timescale 1ns/100ps
module test_osc_ref_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] modulus = 7'd1;
    logic       in_sel = 1'b1;
    logic       sync_pol = 1'b0;
    logic       sync_in = 1'b0;
    logic       lock_flag = 1'b0;
    logic [1:0] stat_sel = 2'b00;
    logic       ref_out, pd_ref, stat_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    osc_ref_mux i_osc_ref_mux (
        .clk(clk), .rst_n(rst_n), .modulus(modulus), .in_sel(in_sel),
        .sync_pol(sync_pol), .sync_in(sync_in), .lock_flag(lock_flag),
        .stat_sel(stat_sel), .ref_out(ref_out), .pd_ref(pd_ref),
        .stat_out(stat_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait until a high cycle begins, as seen between edges.
    task automatic align_high();
        while (ref_out !== 1'b0) @(negedge clk);
        while (ref_out !== 1'b1) @(negedge clk);
    endtask

    // Apply a modulus and measure one full period started after it.
    task automatic measure(input int m, input string req);
        int hi;
        int lo;
        int eff;
        modulus = 7'(m);
        eff = (m == 0) ? 1 : m;
        align_high();
        hi = 0;
        while (ref_out === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (ref_out === 1'b0) begin lo++; @(negedge clk); end
        check("R1 high length", hi, 1);
        check(req, lo, eff + 1);
    endtask

    initial begin
        int hi;
        int lo;
        // R9: reset state and first high cycle
        repeat (3) @(negedge clk);
        check("R9 ref low in reset", int'(ref_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 first high after release", int'(ref_out), 1);

        // R2 / R3: sweep every modulus value
        for (int m = 0; m < 128; m++) begin
            if (m == 0) measure(m, "R3 modulus zero low length");
            else        measure(m, "R2 low length");
        end

        // R4: change the modulus in the middle of a low phase
        modulus = 7'd20;
        align_high();
        @(negedge clk);
        lo = 0;
        while (ref_out === 1'b0) begin
            lo++;
            if (lo == 3) modulus = 7'd5;
            @(negedge clk);
        end
        check("R4 low phase keeps old modulus", lo, 21);
        hi = 0;
        while (ref_out === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (ref_out === 1'b0) begin lo++; @(negedge clk); end
        check("R4 next period uses new modulus", lo, 6);
        check("R1 high length after change", hi, 1);

        // R5: sync path with polarity, then divided path ignoring sync
        in_sel = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 2; s++) begin
                sync_pol = p[0];
                sync_in  = s[0];
                #1;
                check("R5 sync xor polarity", int'(pd_ref), p ^ s);
            end
        end
        in_sel = 1'b1;
        modulus = 7'd2;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            sync_in  = k[0];
            sync_pol = k[1];
            #1;
            check("R5 divided reference selected", int'(pd_ref), int'(ref_out));
        end

        // R6 / R7 / R8: status codes over all input combinations
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 16; v++) begin
                int exp_ref;
                int exp;
                @(negedge clk);
                stat_sel  = 2'(c);
                lock_flag = v[0];
                in_sel    = v[1];
                sync_in   = v[2];
                sync_pol  = v[3];
                #1;
                exp_ref = in_sel ? int'(ref_out) : (v[2] ^ v[3]);
                if (c == 0)      begin exp = v[0];  check("R6 lock code",     int'(stat_out), exp); end
                else if (c == 3) begin exp = exp_ref; check("R7 reference code", int'(stat_out), exp); end
                else             begin exp = 0;     check("R8 reserved code", int'(stat_out), exp); end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule